// File: doc/BRIEF.md
# DTS-CD Sync Word Detector

This block watches a stream of 16-bit sample words taken from a PCM audio link. It looks for the sync word of a DTS-coded bitstream carried in CD-style PCM samples. The sync word can arrive in two packings: a 16-bit form spread over two words and a 14-bit form spread over three words. Each packing has its own enable input.

Each time an enabled form completes, the block emits a one-cycle pulse and raises a status flag. The flag stays high while syncs keep arriving. After the last sync, the block counts frame strobes. The flag falls when a fixed number of frames (4096 by default) has passed with no new sync. It then stays low until the next match.

The surrounding receiver supplies three things: the words with a valid strobe, a frame strobe once per audio frame, and the two enables. Downstream logic uses the flag to mute or reroute the PCM path, and uses the pulse to align a bitstream parser.

Top module: `dtscd_sync_detect`

## Requirements
- R1: After reset, `sync_flag_o` and `sync_pulse_o` are both 0.
- R2: With `en16_i` high, a valid word 0x7FFE followed by the valid word 0x8001 produces `sync_pulse_o` = 1 and `sync_flag_o` = 1 in the cycle after the edge that samples 0x8001.
- R3: With `en14_i` high, the valid words 0x1FFF, 0xE800 and then a word whose upper 12 bits are 0x07F produce the same pulse and flag as in R2. Bits 3:0 of the third word are ignored.
- R4: With `en16_i` low, the 16-bit form produces no pulse and does not raise the flag.
- R5: With `en14_i` low, the 14-bit form produces no pulse and does not raise the flag.
- R6: Cycles with `word_vld_i` low do not advance or break a partial sequence. Any valid word that is out of sequence breaks it, so the sequence does not match.
- R7: Counting from the last sync match, the flag stays high through 4095 frame strobes (`TIMEOUT_FRAMES`-1) and is 0 in the cycle after the edge that samples the 4096th strobe.
- R8: A sync match while the flag is high restarts the frame count from zero.
- R9: Dropping an enable while the flag is high does not lower the flag. The flag still ends only by timeout, and the disabled form cannot restart the count.
- R10: `sync_pulse_o` lasts exactly one cycle per match. After a timeout, the flag stays 0 through further frame strobes until a new match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_i | input | 16 | Received sample word |
| word_vld_i | input | 1 | Qualifies `word_i` for one cycle |
| frame_stb_i | input | 1 | One-cycle strobe per audio frame |
| en16_i | input | 1 | Enables the 16-bit packed sync form |
| en14_i | input | 1 | Enables the 14-bit packed sync form |
| sync_flag_o | output | 1 | High from a sync match until the timeout |
| sync_pulse_o | output | 1 | One-cycle pulse per enabled sync match |

## Verification
The hardest situation to reach is the exact timeout edge, since only the 4096th frame strobe with no match may clear the flag. The stimulus drives runs of exactly 4095 strobes, checks the flag, then adds one more strobe. It does this after a plain sync, after a restarting sync, and after an enable is dropped mid-hold. The enables and the ignored low nibble of the 14-bit tail are swept exhaustively, with a reset between cases so that a low flag is observable.

// File: rtl/dtsd_pkg.sv
package dtsd_pkg;
  localparam int unsigned WORD_W = 16;

  // 16-bit packed form: two words
  localparam logic [WORD_W-1:0] P16_HEAD = 16'h7FFE;
  localparam logic [WORD_W-1:0] P16_TAIL = 16'h8001;

  // 14-bit packed form: three words, last compared on upper bits only
  localparam logic [WORD_W-1:0] P14_W0   = 16'h1FFF;
  localparam logic [WORD_W-1:0] P14_W1   = 16'hE800;
  localparam logic [WORD_W-1:0] P14_W2   = 16'h07F0;
  localparam logic [WORD_W-1:0] P14_MASK = 16'hFFF0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GOT0 = 2'd1,
    ST_GOT1 = 2'd2
  } p14_state_t;
endpackage

// File: rtl/dtsd_match16.sv
module dtsd_match16
  import dtsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              vld_i,
  input  logic              en_i,
  output logic              match_o
);
  logic head_q, head_d;

  always_comb begin
    head_d = head_q;
    if (vld_i) head_d = (word_i == P16_HEAD);
    match_o = en_i && vld_i && head_q && (word_i == P16_TAIL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) head_q <= 1'b0;
    else        head_q <= head_d;
  end

  // a completed pair implies the head word was seen on a valid cycle
  assert_head_seen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    head_q |-> $past(vld_i) || $past(head_q));
endmodule

// File: rtl/dtsd_match14.sv
module dtsd_match14
  import dtsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              vld_i,
  input  logic              en_i,
  output logic              match_o
);
  p14_state_t st_q, st_d;

  always_comb begin
    st_d    = st_q;
    match_o = 1'b0;
    if (vld_i) begin
      if (word_i == P14_W0)                       st_d = ST_GOT0;
      else if (st_q == ST_GOT0 && word_i == P14_W1) st_d = ST_GOT1;
      else                                        st_d = ST_IDLE;
      match_o = en_i && (st_q == ST_GOT1) &&
                ((word_i & P14_MASK) == P14_W2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assert_state_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 2'd3);

  assert_hold_on_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(st_q));
endmodule

// File: rtl/dtsd_hold_timer.sv
module dtsd_hold_timer #(
  parameter int unsigned TIMEOUT_FRAMES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic frame_stb_i,
  output logic flag_o
);
  localparam int unsigned CNT_W = (TIMEOUT_FRAMES > 2) ? $clog2(TIMEOUT_FRAMES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_FRAMES - 1);

  logic             flag_q, flag_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    flag_d = flag_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (hit_i) begin
      flag_d = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (flag_q && frame_stb_i) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        flag_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
    end
  end

  assign flag_o = flag_q;

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_fall_on_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(frame_stb_i) && !$past(hit_i));

  assert_idle_count_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q |-> cnt_q == '0);
endmodule

// File: rtl/dtscd_sync_detect.sv
module dtscd_sync_detect
  import dtsd_pkg::*;
#(
  parameter int unsigned TIMEOUT_FRAMES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              frame_stb_i,
  input  logic              en16_i,
  input  logic              en14_i,
  output logic              sync_flag_o,
  output logic              sync_pulse_o
);
  logic hit16, hit14, hit_any;
  logic pulse_q;

  dtsd_match16 i_m16 (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .vld_i(word_vld_i),
    .en_i(en16_i), .match_o(hit16)
  );

  dtsd_match14 i_m14 (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .vld_i(word_vld_i),
    .en_i(en14_i), .match_o(hit14)
  );

  assign hit_any = hit16 | hit14;

  dtsd_hold_timer #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) i_tmr (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_any), .frame_stb_i(frame_stb_i),
    .flag_o(sync_flag_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= hit_any;
  end

  assign sync_pulse_o = pulse_q;

  assert_pulse_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse_o |-> sync_flag_o);

  assert_rise_has_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_flag_o) |-> sync_pulse_o);

  assert_pulse_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse_o |-> $past(en16_i || en14_i) && $past(word_vld_i));
endmodule

// File: tb/test_dtscd_sync_detect.sv
module test_dtscd_sync_detect;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] word_i;
  logic        word_vld_i, frame_stb_i, en16_i, en14_i;
  logic        sync_flag_o, sync_pulse_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dtscd_sync_detect i_dtscd_sync_detect (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_vld_i(word_vld_i),
    .frame_stb_i(frame_stb_i), .en16_i(en16_i), .en14_i(en14_i),
    .sync_flag_o(sync_flag_o), .sync_pulse_o(sync_pulse_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; word_vld_i = 1'b0; frame_stb_i = 1'b0; word_i = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive one valid word; return at the negedge after it was sampled
  task automatic put(input logic [15:0] w);
    @(negedge clk);
    word_i = w; word_vld_i = 1'b1;
    @(negedge clk);
    word_vld_i = 1'b0;
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_stb_i = 1'b1;
      @(negedge clk); frame_stb_i = 1'b0;
    end
  endtask

  task automatic sync16(); put(16'h7FFE); put(16'h8001); endtask
  task automatic sync14(input logic [3:0] lo);
    put(16'h1FFF); put(16'hE800); put({12'h07F, lo});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; word_i = '0; word_vld_i = 1'b0; frame_stb_i = 1'b0;
    en16_i = 1'b1; en14_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 flag", sync_flag_o, 0);
    chk("R1 pulse", sync_pulse_o, 0);
    rst_n = 1'b1;

    // R2/R4/R5: sweep both enables for both forms
    for (int e = 0; e < 4; e++) begin
      en16_i = e[0]; en14_i = e[1];
      do_reset();
      sync16();
      chk(e[0] ? "R2 pulse16" : "R4 pulse16", sync_pulse_o, e[0]);
      chk(e[0] ? "R2 flag16" : "R4 flag16", sync_flag_o, e[0]);
      do_reset();
      sync14(4'h0);
      chk(e[1] ? "R3 pulse14" : "R5 pulse14", sync_pulse_o, e[1]);
      chk(e[1] ? "R3 flag14" : "R5 flag14", sync_flag_o, e[1]);
    end
    en16_i = 1'b1; en14_i = 1'b1;

    // R3: every low nibble of the 14-bit tail
    for (int lo = 0; lo < 16; lo++) begin
      do_reset();
      sync14(lo[3:0]);
      chk("R3 nibble", sync_pulse_o, 1);
    end
    do_reset();
    sync14(4'h0); put(16'h1FFF); put(16'hE800); put(16'h07E0);
    chk("R3 upper bits compared", sync_pulse_o, 0);

    // R10: pulse width
    do_reset();
    sync16();
    chk("R10 pulse high", sync_pulse_o, 1);
    @(negedge clk);
    chk("R10 pulse one cycle", sync_pulse_o, 0);

    // R6: idle gaps do not break; stray words do
    do_reset();
    put(16'h7FFE); repeat (5) @(negedge clk); put(16'h8001);
    chk("R6 gap16", sync_pulse_o, 1);
    do_reset();
    put(16'h1FFF); repeat (3) @(negedge clk); put(16'hE800);
    repeat (4) @(negedge clk); put(16'h07F5);
    chk("R6 gap14", sync_pulse_o, 1);
    do_reset();
    put(16'h7FFE); put(16'h1234); put(16'h8001);
    chk("R6 break16", sync_flag_o, 0);
    do_reset();
    put(16'h1FFF); put(16'hE800); put(16'h0000); put(16'h07F0);
    chk("R6 break14", sync_flag_o, 0);

    // R7: timeout edge
    do_reset();
    sync16();
    frames(4095);
    chk("R7 held 4095", sync_flag_o, 1);
    frames(1);
    chk("R7 drop 4096", sync_flag_o, 0);
    frames(10);
    chk("R10 stays low", sync_flag_o, 0);
    sync14(4'hA);
    chk("R10 re-arm", sync_flag_o, 1);

    // R8: restart
    do_reset();
    sync16();
    frames(3000);
    sync14(4'h3);
    frames(4095);
    chk("R8 restarted hold", sync_flag_o, 1);
    frames(1);
    chk("R8 drop", sync_flag_o, 0);

    // R9: disabling mid-hold
    do_reset();
    sync16();
    en16_i = 1'b0;
    @(negedge clk);
    chk("R9 flag kept", sync_flag_o, 1);
    frames(2000);
    sync16();
    chk("R9 no pulse disabled", sync_pulse_o, 0);
    frames(2095);
    chk("R9 held", sync_flag_o, 1);
    frames(1);
    chk("R9 timeout", sync_flag_o, 0);
    en16_i = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule